// File: doc/BRIEF.md
# Program Counter with Hardware Return Stack

This block keeps the fetch address of a small microcontroller core. Each cycle it either holds the address or moves it by one of five operations: a sequential step, a branch load, a subroutine call, a return, or an interrupt entry. Calls and interrupt entries save the address of the next sequential instruction on a small stack that lives only in hardware. A return takes it back.

The counter is 13 bits wide, but only the lower 4K words of program space exist. Every address the counter takes is folded into that implemented range, so a fetch that runs past the top wraps to the bottom. Reset starts execution at address zero, and an interrupt entry always goes to address 0004h. The stack has eight entries and is circular. When a ninth save arrives, it silently replaces the oldest entry.

Top module: `pcs_pc_unit`

## Requirements
- R1: `pc` is 13 bits wide and always lies in 0000h–0FFFh. Any target or sum is reduced by dropping bit 12, so 1005h becomes 0005h and a step from 0FFFh gives 0000h.
- R2: While `rst_n` is low, `pc` is 0000h, `depth` is 0, the stack pointer is at slot 0 and every stack entry is 0000h.
- R3: With `inc_en` as the only active request, `pc` becomes (pc+1) folded into range on the next edge, and `depth` does not change.
- R4: `irq_en` saves (pc+1) folded into range on the stack and sets `pc` to 0004h on the next edge.
- R5: `call_en` saves (pc+1) folded into range on the stack and sets `pc` to `call_addr` folded into range.
- R6: `ld_en` sets `pc` to `ld_addr` folded into range. It leaves the stack contents, the pointer and `depth` unchanged.
- R7: `ret_en` moves the stack pointer back one slot and sets `pc` to the entry in that slot. `depth` then drops by one but never goes below 0.
- R8: The stack holds 8 entries in a circular buffer. A save that arrives when `depth` is 8 overwrites the oldest entry, and `depth` stays at 8. No flag is raised.
- R9: A return while `depth` is 0 still moves the pointer back one slot and loads whatever that slot holds. `depth` stays 0 and no flag is raised.
- R10: When several requests are active in one cycle, only the highest one acts and the others are ignored. The order from highest to lowest is `irq_en`, `call_en`, `ld_en`, `ret_en`, `inc_en`.
- R11: Only calls, interrupt entries and returns change the stack. A branch load or a step placed between a save and its return does not alter the entry that the return gives back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Step to the next sequential address |
| ld_en | input | 1 | Load a branch target |
| ld_addr | input | 13 | Branch target |
| call_en | input | 1 | Subroutine call |
| call_addr | input | 13 | Call target |
| ret_en | input | 1 | Return (plain, from interrupt, or with literal) |
| irq_en | input | 1 | Interrupt entry |
| pc | output | 13 | Current fetch address |
| depth | output | 4 | Number of valid saved entries, 0 to 8 |

## Verification
The bench builds the block with its default parameters: a 13-bit counter, 12 implemented address bits and an 8-deep stack. Using the real 12-bit fold lets directed loads reach 0FFFh and the upper half of the space (1FFEh, 1005h) in a few cycles, so the wrap cases are hit directly. An 8-deep stack is shallow enough that nine calls followed by nine returns drive the overwrite-when-full case and the empty-pop case in under twenty cycles. Each cycle, a behavioural model built from an integer array and a pointer is compared with `pc` and `depth`. After the directed cases comes a long run with random, overlapping requests that exercises the priority order.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INC  = 3'd1,
    OP_LOAD = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_IRQ  = 3'd5
  } pc_op_e;

  localparam int unsigned NUM_REQ = 5;

endpackage

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
  import pcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc_en,
  input  logic                ld_en,
  input  logic                call_en,
  input  logic                ret_en,
  input  logic                irq_en,
  output pc_op_e              op,
  output logic [NUM_REQ-1:0]  grant
);

  // grant bit order: 4 irq, 3 call, 2 load, 1 ret, 0 inc
  always_comb begin
    grant = '0;
    op    = OP_HOLD;
    if (irq_en) begin
      op       = OP_IRQ;
      grant[4] = 1'b1;
    end else if (call_en) begin
      op       = OP_CALL;
      grant[3] = 1'b1;
    end else if (ld_en) begin
      op       = OP_LOAD;
      grant[2] = 1'b1;
    end else if (ret_en) begin
      op       = OP_RET;
      grant[1] = 1'b1;
    end else if (inc_en) begin
      op       = OP_INC;
      grant[0] = 1'b1;
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R10
  AST_IRQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en |-> (grant == 5'b10000)); // R10
  AST_RET_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && (call_en || ld_en)) |-> !grant[1]); // R10

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int unsigned AW    = 13,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [AW-1:0]    push_data,
  output logic [AW-1:0]    top_data,
  output logic [CNT_W-1:0] depth
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [AW-1:0]    slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] ptr_inc;
  logic [PTR_W-1:0] ptr_dec;
  logic [DEPTH-1:0] slot_we;
  logic             at_full;
  logic             at_empty;

  assign ptr_inc  = (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + PTR_W'(1);
  assign ptr_dec  = (wr_ptr == '0) ? LAST_SLOT : wr_ptr - PTR_W'(1);
  assign at_full  = (depth == FULL_CNT);
  assign at_empty = (depth == '0);
  assign top_data = slots[ptr_dec];

  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign slot_we[g] = push && (wr_ptr == PTR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (slot_we[i]) slots[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      depth  <= '0;
    end else if (push) begin
      wr_ptr <= ptr_inc;
      if (!at_full) depth <= depth + CNT_W'(1);
    end else if (pop) begin
      wr_ptr <= ptr_dec;
      if (!at_empty) depth <= depth - CNT_W'(1);
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULL_CNT); // R8
  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && at_full) |=> (depth == FULL_CNT)); // R8
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !at_full) |=> (depth == $past(depth) + CNT_W'(1))); // R8
  AST_EMPTY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && at_empty) |=> (depth == '0)); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(depth)); // R11

endmodule

// File: rtl/pcs_next_addr.sv
module pcs_next_addr
  import pcs_pkg::*;
#(
  parameter int unsigned    PC_W    = 13,
  parameter int unsigned    IMPL_W  = 12,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
  input  pc_op_e          op,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] ld_addr,
  input  logic [PC_W-1:0] call_addr,
  input  logic [PC_W-1:0] top_data,
  output logic [PC_W-1:0] pc_next,
  output logic [PC_W-1:0] seq_addr
);

  localparam logic [PC_W-1:0] IMPL_MASK = {PC_W{1'b1}} >> (PC_W - IMPL_W);

  function automatic logic [PC_W-1:0] fold(input logic [PC_W-1:0] a);
    return a & IMPL_MASK;
  endfunction

  function automatic logic [PC_W-1:0] step(input logic [PC_W-1:0] a);
    return fold(a + PC_W'(1));
  endfunction

  assign seq_addr = step(pc);

  always_comb begin
    unique case (op)
      OP_IRQ:  pc_next = fold(IRQ_VEC);
      OP_CALL: pc_next = fold(call_addr);
      OP_LOAD: pc_next = fold(ld_addr);
      OP_RET:  pc_next = fold(top_data);
      OP_INC:  pc_next = seq_addr;
      default: pc_next = pc;
    endcase
  end

endmodule

// File: rtl/pcs_pc_unit.sv
module pcs_pc_unit
  import pcs_pkg::*;
#(
  parameter int unsigned     PC_W      = 13,
  parameter int unsigned     IMPL_W    = 12,
  parameter int unsigned     STK_DEPTH = 8,
  parameter logic [PC_W-1:0] RST_VEC   = 13'h0000,
  parameter logic [PC_W-1:0] IRQ_VEC   = 13'h0004,
  localparam int unsigned    CNT_W     = $clog2(STK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic             ld_en,
  input  logic [PC_W-1:0]  ld_addr,
  input  logic             call_en,
  input  logic [PC_W-1:0]  call_addr,
  input  logic             ret_en,
  input  logic             irq_en,
  output logic [PC_W-1:0]  pc,
  output logic [CNT_W-1:0] depth
);

  localparam logic [PC_W-1:0] IMPL_MASK = {PC_W{1'b1}} >> (PC_W - IMPL_W);

  pc_op_e              op;
  logic [NUM_REQ-1:0]  grant;
  logic                do_push;
  logic                do_pop;
  logic [PC_W-1:0]     pc_next;
  logic [PC_W-1:0]     seq_addr;
  logic [PC_W-1:0]     top_data;

  pcs_arbiter i_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (inc_en),
    .ld_en   (ld_en),
    .call_en (call_en),
    .ret_en  (ret_en),
    .irq_en  (irq_en),
    .op      (op),
    .grant   (grant)
  );

  assign do_push = (op == OP_CALL) || (op == OP_IRQ);
  assign do_pop  = (op == OP_RET);

  pcs_next_addr #(
    .PC_W    (PC_W),
    .IMPL_W  (IMPL_W),
    .IRQ_VEC (IRQ_VEC)
  ) i_nxt (
    .op        (op),
    .pc        (pc),
    .ld_addr   (ld_addr),
    .call_addr (call_addr),
    .top_data  (top_data),
    .pc_next   (pc_next),
    .seq_addr  (seq_addr)
  );

  pcs_stack #(
    .AW    (PC_W),
    .DEPTH (STK_DEPTH)
  ) i_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_push),
    .pop       (do_pop),
    .push_data (seq_addr),
    .top_data  (top_data),
    .depth     (depth)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= RST_VEC & IMPL_MASK;
    else        pc <= pc_next;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_STATE: assert (pc == '0 && depth == '0); // R2
    end
  end

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc & ~IMPL_MASK) == '0); // R1
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 5'b00001) |=> (pc == (($past(pc) + PC_W'(1)) & IMPL_MASK))); // R3
  AST_IRQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en |=> (pc == (IRQ_VEC & IMPL_MASK))); // R4
  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (call_en && !irq_en) |=> (pc == ($past(call_addr) & IMPL_MASK))); // R5
  AST_LOAD_KEEPS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !call_en && !irq_en) |=> $stable(depth)); // R6
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 5'b00010) |=> (pc == ($past(top_data) & IMPL_MASK))); // R7

endmodule

// File: tb/test_pcs_pc_unit.sv
`timescale 1ns/1ps
module test_pcs_pc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_en = 1'b0, ld_en = 1'b0, call_en = 1'b0, ret_en = 1'b0, irq_en = 1'b0;
  logic [12:0] ld_addr = '0, call_addr = '0;
  logic [12:0] pc;
  logic [3:0]  depth;

  int n_cmp = 0;
  int n_bad = 0;

  int m_stk [8];
  int m_ptr;
  int m_depth;
  int m_pc;

  always #4 clk = ~clk;

  pcs_pc_unit i_pcs_pc_unit (
    .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .ld_en(ld_en), .ld_addr(ld_addr),
    .call_en(call_en), .call_addr(call_addr), .ret_en(ret_en), .irq_en(irq_en),
    .pc(pc), .depth(depth)
  );

  function automatic int fold(int a);
    return a % 4096;
  endfunction

  task automatic model_reset();
    foreach (m_stk[i]) m_stk[i] = 0;
    m_ptr = 0; m_depth = 0; m_pc = 0;
  endtask

  task automatic model_push(int v);
    m_stk[m_ptr] = v;
    m_ptr = (m_ptr + 1) % 8;
    if (m_depth < 8) m_depth++;
  endtask

  task automatic model_tick(bit i, bit l, bit c, bit r, bit q, int la, int ca);
    int nxt;
    nxt = fold(m_pc + 1);
    if (q) begin model_push(nxt); m_pc = 4; end
    else if (c) begin model_push(nxt); m_pc = fold(ca); end
    else if (l) m_pc = fold(la);
    else if (r) begin
      m_ptr = (m_ptr + 7) % 8;
      m_pc = m_stk[m_ptr];
      if (m_depth > 0) m_depth--;
    end
    else if (i) m_pc = nxt;
  endtask

  task automatic compare(string tag);
    n_cmp++;
    if (int'(pc) != m_pc || int'(depth) != m_depth) begin
      n_bad++;
      $display("FAIL %s: pc=%h depth=%0d expected pc=%h depth=%0d",
               tag, pc, depth, m_pc[12:0], m_depth);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(string tag, bit i, bit l, bit c, bit r, bit q,
                      logic [12:0] la, logic [12:0] ca);
    inc_en = i; ld_en = l; call_en = c; ret_en = r; irq_en = q;
    ld_addr = la; call_addr = ca;
    @(posedge clk);
    model_tick(i, l, c, r, q, int'(la), int'(ca));
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R2 reset");
    rst_n = 1'b1;

    step("R3 step", 1, 0, 0, 0, 0, 0, 0);
    step("R3 step", 1, 0, 0, 0, 0, 0, 0);
    step("R6 load", 0, 1, 0, 0, 0, 13'h0123, 0);
    step("R1 load high", 0, 1, 0, 0, 0, 13'h1FFE, 0);
    step("R1 step to top", 1, 0, 0, 0, 0, 0, 0);
    step("R1 step wrap", 1, 0, 0, 0, 0, 0, 0);
    step("R3 hold", 0, 0, 0, 0, 0, 0, 0);
    step("R5 call", 0, 0, 1, 0, 0, 0, 13'h1005);
    step("R4 irq", 0, 0, 0, 0, 1, 0, 0);
    step("R11 load mid", 0, 1, 0, 0, 0, 13'h0777, 0);
    step("R11 step mid", 1, 0, 0, 0, 0, 0, 0);
    step("R7 ret irq", 0, 0, 0, 1, 0, 0, 0);
    step("R7 ret call", 0, 0, 0, 1, 0, 0, 0);
    step("R9 ret empty", 0, 0, 0, 1, 0, 0, 0);

    for (int k = 0; k < 9; k++)
      step("R8 fill", 0, 0, 1, 0, 0, 0, 13'(16 * k + 32));
    for (int k = 0; k < 8; k++)
      step("R8 drain", 0, 0, 0, 1, 0, 0, 0);
    step("R9 empty pop", 0, 0, 0, 1, 0, 0, 0);
    step("R9 empty pop again", 0, 0, 0, 1, 0, 0, 0);

    step("R10 all", 1, 1, 1, 1, 1, 13'h0200, 13'h0300);
    step("R10 call over load", 1, 1, 1, 1, 0, 13'h0200, 13'h0300);
    step("R10 load over ret", 1, 1, 0, 1, 0, 13'h0400, 0);
    step("R10 ret over inc", 1, 0, 0, 1, 0, 0, 0);

    for (int k = 0; k < 3000; k++) begin
      int rv;
      rv = $urandom_range(0, 99);
      step("R10 random",
           rv < 70, rv % 11 == 0, rv % 13 == 0, rv % 5 == 0, rv % 29 == 0,
           13'($urandom_range(0, 8191)), 13'($urandom_range(0, 8191)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule